// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the horizontal sync, vertical sync, blanking and display-enable signals for a raster display, together with the current pixel column and line number. Each axis is described by four cumulative positions: where sync ends, where active video starts, where active video ends, and the total count. Every edge is therefore an absolute counter value and not a duration. A separately selectable line produces a one-cycle vertical event pulse that can drive an interrupt.

Software writes the timing values through a simple write port (`wr_en`, `wr_addr`, `wr_data`) into a pending register set. The pending set is copied into the working set at two points only: when generation starts, and at the last pixel of every frame. As a result, no frame ever mixes old and new timing. A control word holds the run bit, the three polarity bits and the event-line select.

The controller is a three-state machine:
- `ST_OFF`: counters are held at zero and the display is blanked.
- `ST_LOAD`: one cycle in which the pending set is copied into the working set.
- `ST_RUN`: counting.

The transitions are:
- `ST_OFF` to `ST_LOAD` when the run bit is set.
- `ST_LOAD` to `ST_RUN` unconditionally.
- `ST_RUN` to `ST_OFF` as soon as the run bit is cleared.
- `ST_RUN` stays in `ST_RUN` while the run bit is set. At each frame end it also copies the pending set.

Top module: `rtg_top`

## Requirements
- R1: After reset, the block holds these values. The state is `ST_OFF` and the run bit is 0. `pix_x` and `line_y` are 0, `disp_en` and `vevent` are 0. All polarity bits are 0, so `hsync` and `vsync` rest high and `blank` is low.
- R2: While running, `pix_x` counts from 0 to the horizontal total minus 1 and then returns to 0. `line_y` advances by one on each horizontal return and goes back to 0 after the vertical total minus 1.
- R3: The horizontal sync is active while `pix_x` < the horizontal sync-end position. The vertical sync is active while `line_y` < the vertical sync-end position.
- R4: `disp_en` is 1 exactly when both of these hold: the horizontal active-start position ≤ `pix_x` < the horizontal active-end position, and the vertical active-start position ≤ `line_y` < the vertical active-end position.
- R5: Control bit 1 sets the level of an active `hsync` and bit 2 sets the level of an active `vsync`. Bit 3 sets the level `blank` takes while not displaying. A value of 1 means active high. When idle, each sync signal sits at the opposite of its active level.
- R6: `vevent` is high for exactly one cycle, at `pix_x` = 0 of the event line. When control bit 4 is 0, the event line is the vertical active-end position. When bit 4 is 1, it is the value at address 8.
- R7: Writing control bit 0 = 1 while idle starts the frame. The first running cycle shows (0,0) two clock edges after the writing edge. Clearing bit 0 returns the block to the idle state on the next edge, with the display blanked and the counters at 0.
- R8: Writes take effect only at a frame start. Timing and control fields written during a frame leave that frame unchanged.
- R9: Writes to addresses 10 to 15 change nothing observable.
- R10: The reset timing is 640×480. The horizontal positions are 96/144/784/800 and the vertical positions are 2/35/515/525. These are at addresses 0–3 (horizontal: sync end, active start, active end, total) and 4–7 (the same order, vertical).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address (0–9 mapped) |
| wr_data | input | 16 | Write data; positions use the low 12 bits, control uses bits 4:0 |
| hsync | output | 1 | Horizontal sync, polarity per control bit 1 |
| vsync | output | 1 | Vertical sync, polarity per control bit 2 |
| blank | output | 1 | Blanking, level per control bit 3 |
| disp_en | output | 1 | Display enable, high inside both active windows |
| pix_x | output | 12 | Current horizontal position |
| line_y | output | 12 | Current line |
| vevent | output | 1 | One-cycle pulse at the event line |

## Verification
Errors in the two counters or in the working set show up at the ports as soon as they occur. `pix_x` and `line_y` are the counters, so a wrong counter is visible on the cycle it goes wrong. A wrong working set moves a sync, enable or event edge in the first line that crosses the affected position. A commit that happens mid-frame shows as a line length that changes before `line_y` has returned to 0. A stuck state shows either as counters that fail to start two edges after the run bit is written, or as counters that keep moving one edge after it is cleared. A reference model in the bench compares every port on every cycle against these rules, including across random timing sets that are rewritten mid-frame.

// File: rtl/rtg_pkg.sv
package rtg_pkg;
    parameter int CNT_W  = 12;
    parameter int REG_AW = 4;
    parameter int REG_DW = 16;

    // default porches and sizes; positions are derived cumulatively
    localparam int DEF_HSYNC = 96;
    localparam int DEF_HBP   = 48;
    localparam int DEF_W     = 640;
    localparam int DEF_HFP   = 16;
    localparam int DEF_VSYNC = 2;
    localparam int DEF_VBP   = 33;
    localparam int DEF_H     = 480;
    localparam int DEF_VFP   = 10;

    localparam int DEF_HAS = DEF_HSYNC + DEF_HBP;
    localparam int DEF_HAE = DEF_HAS + DEF_W;
    localparam int DEF_HT  = DEF_HAE + DEF_HFP;
    localparam int DEF_VAS = DEF_VSYNC + DEF_VBP;
    localparam int DEF_VAE = DEF_VAS + DEF_H;
    localparam int DEF_VT  = DEF_VAE + DEF_VFP;

    localparam int CTL_RUN   = 0;
    localparam int CTL_HPOL  = 1;
    localparam int CTL_VPOL  = 2;
    localparam int CTL_BPOL  = 3;
    localparam int CTL_EVSEL = 4;
    localparam int CTL_W     = 5;

    typedef enum logic [REG_AW-1:0] {
        RA_H_SYNC_END  = 4'd0,
        RA_H_ACT_START = 4'd1,
        RA_H_ACT_END   = 4'd2,
        RA_H_TOTAL     = 4'd3,
        RA_V_SYNC_END  = 4'd4,
        RA_V_ACT_START = 4'd5,
        RA_V_ACT_END   = 4'd6,
        RA_V_TOTAL     = 4'd7,
        RA_EV_LINE     = 4'd8,
        RA_CTRL        = 4'd9
    } reg_addr_e;

    localparam int LAST_ADDR = 9;

    typedef struct packed {
        logic [CNT_W-1:0] sync_end;
        logic [CNT_W-1:0] act_start;
        logic [CNT_W-1:0] act_end;
        logic [CNT_W-1:0] total;
    } axis_cfg_t;

    typedef struct packed {
        axis_cfg_t        h;
        axis_cfg_t        v;
        logic [CNT_W-1:0] ev_line;
        logic             ev_sel;
        logic             hs_pol;
        logic             vs_pol;
        logic             bl_pol;
    } tcfg_t;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_LOAD = 2'd1,
        ST_RUN  = 2'd2
    } gen_state_e;

    localparam tcfg_t CFG_RESET = '{
        h: '{sync_end: CNT_W'(DEF_HSYNC), act_start: CNT_W'(DEF_HAS),
             act_end: CNT_W'(DEF_HAE), total: CNT_W'(DEF_HT)},
        v: '{sync_end: CNT_W'(DEF_VSYNC), act_start: CNT_W'(DEF_VAS),
             act_end: CNT_W'(DEF_VAE), total: CNT_W'(DEF_VT)},
        ev_line: CNT_W'(DEF_VAE),
        ev_sel: 1'b0,
        hs_pol: 1'b0,
        vs_pol: 1'b0,
        bl_pol: 1'b0
    };
endpackage

// File: rtl/rtg_regfile.sv
module rtg_regfile
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output tcfg_t             pend,
    output logic              run_req
);
    logic [CNT_W-1:0] pos_val;
    logic [CTL_W-1:0] ctl_val;

    assign pos_val = wr_data[CNT_W-1:0];
    assign ctl_val = wr_data[CTL_W-1:0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend    <= CFG_RESET;
            run_req <= 1'b0;
        end else if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_H_SYNC_END:  pend.h.sync_end  <= pos_val;
                RA_H_ACT_START: pend.h.act_start <= pos_val;
                RA_H_ACT_END:   pend.h.act_end   <= pos_val;
                RA_H_TOTAL:     pend.h.total     <= pos_val;
                RA_V_SYNC_END:  pend.v.sync_end  <= pos_val;
                RA_V_ACT_START: pend.v.act_start <= pos_val;
                RA_V_ACT_END:   pend.v.act_end   <= pos_val;
                RA_V_TOTAL:     pend.v.total     <= pos_val;
                RA_EV_LINE:     pend.ev_line     <= pos_val;
                RA_CTRL: begin
                    run_req     <= ctl_val[CTL_RUN];
                    pend.hs_pol <= ctl_val[CTL_HPOL];
                    pend.vs_pol <= ctl_val[CTL_VPOL];
                    pend.bl_pol <= ctl_val[CTL_BPOL];
                    pend.ev_sel <= ctl_val[CTL_EVSEL];
                end
                default: ;
            endcase
        end
    end

    AST_IGNORE_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (int'(wr_addr) > LAST_ADDR)) |=> ($stable(pend) && $stable(run_req))); // R9
endmodule

// File: rtl/rtg_axis.sv
module rtg_axis
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  axis_cfg_t        cfg,
    output logic [CNT_W-1:0] cnt,
    output logic             last,
    output logic             in_sync,
    output logic             in_act
);
    assign last    = (cnt == (cfg.total - CNT_W'(1)));
    assign in_sync = (cnt < cfg.sync_end);
    assign in_act  = (cnt >= cfg.act_start) && (cnt < cfg.act_end);

    always_ff @(posedge clk) begin
        if (!rst_n)      cnt <= '0;
        else if (clr)    cnt <= '0;
        else if (step)   cnt <= last ? '0 : cnt + CNT_W'(1);
    end

    AST_CNT_BELOW_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.total != '0) |-> (cnt < cfg.total)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && last && !clr) |=> (cnt == '0)); // R2
endmodule

// File: rtl/rtg_ctrl.sv
module rtg_ctrl
    import rtg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  tcfg_t            pend,
    input  logic             run_req,
    input  logic [CNT_W-1:0] h_cnt,
    input  logic [CNT_W-1:0] v_cnt,
    input  logic             h_last,
    input  logic             v_last,
    input  logic             h_sync_in,
    input  logic             v_sync_in,
    input  logic             h_act_in,
    input  logic             v_act_in,
    output axis_cfg_t        h_cfg,
    output axis_cfg_t        v_cfg,
    output logic             cnt_clr,
    output logic             running,
    output logic             hsync,
    output logic             vsync,
    output logic             blank,
    output logic             disp_en,
    output logic             vevent
);
    gen_state_e       state, nxt;
    tcfg_t            act;
    logic             frame_end;
    logic             commit;
    logic [CNT_W-1:0] ev_target;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_OFF:  nxt = run_req ? ST_LOAD : ST_OFF;
            ST_LOAD: nxt = ST_RUN;
            ST_RUN:  nxt = run_req ? ST_RUN : ST_OFF;
            default: nxt = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_OFF;
        else        state <= nxt;
    end

    assign frame_end = (state == ST_RUN) && h_last && v_last;
    assign commit    = (state == ST_LOAD) || (frame_end && run_req);

    always_ff @(posedge clk) begin
        if (!rst_n)      act <= CFG_RESET;
        else if (commit) act <= pend;
    end

    assign h_cfg     = act.h;
    assign v_cfg     = act.v;
    assign ev_target = act.ev_sel ? act.ev_line : act.v.act_end;

    always_comb begin
        running = (state == ST_RUN);
        cnt_clr = (state != ST_RUN) || !run_req;
        disp_en = running && h_act_in && v_act_in;
        hsync   = (running && h_sync_in) ? act.hs_pol : !act.hs_pol;
        vsync   = (running && v_sync_in) ? act.vs_pol : !act.vs_pol;
        blank   = disp_en ? !act.bl_pol : act.bl_pol;
        vevent  = running && (h_cnt == '0) && (v_cnt == ev_target);
    end

    AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |=> (state == ST_RUN)); // R7
    AST_STOP_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !run_req) |=> (!disp_en && h_cnt == '0 && v_cnt == '0)); // R7
    AST_CFG_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RUN && !(h_last && v_last)) |=> $stable(act)); // R8
    AST_EVENT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (vevent && act.h.total > CNT_W'(1)) |=> !vevent); // R6
endmodule

// File: rtl/rtg_top.sv
module rtg_top
    import rtg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    output logic              hsync,
    output logic              vsync,
    output logic              blank,
    output logic              disp_en,
    output logic [CNT_W-1:0]  pix_x,
    output logic [CNT_W-1:0]  line_y,
    output logic              vevent
);
    localparam int N_AXIS = 2;

    tcfg_t            pend;
    logic             run_req;
    logic             cnt_clr;
    logic             running;
    axis_cfg_t        ax_cfg  [N_AXIS];
    logic             ax_step [N_AXIS];
    logic [CNT_W-1:0] ax_cnt  [N_AXIS];
    logic             ax_last [N_AXIS];
    logic             ax_sync [N_AXIS];
    logic             ax_act  [N_AXIS];
    axis_cfg_t        h_cfg, v_cfg;

    rtg_regfile u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .pend    (pend),
        .run_req (run_req)
    );

    assign ax_cfg[0]  = h_cfg;
    assign ax_cfg[1]  = v_cfg;
    assign ax_step[0] = running;
    assign ax_step[1] = running && ax_last[0];

    for (genvar a = 0; a < N_AXIS; a++) begin : g_axis
        rtg_axis u_axis (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (cnt_clr),
            .step    (ax_step[a]),
            .cfg     (ax_cfg[a]),
            .cnt     (ax_cnt[a]),
            .last    (ax_last[a]),
            .in_sync (ax_sync[a]),
            .in_act  (ax_act[a])
        );
    end

    rtg_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .run_req   (run_req),
        .h_cnt     (ax_cnt[0]),
        .v_cnt     (ax_cnt[1]),
        .h_last    (ax_last[0]),
        .v_last    (ax_last[1]),
        .h_sync_in (ax_sync[0]),
        .v_sync_in (ax_sync[1]),
        .h_act_in  (ax_act[0]),
        .v_act_in  (ax_act[1]),
        .h_cfg     (h_cfg),
        .v_cfg     (v_cfg),
        .cnt_clr   (cnt_clr),
        .running   (running),
        .hsync     (hsync),
        .vsync     (vsync),
        .blank     (blank),
        .disp_en   (disp_en),
        .vevent    (vevent)
    );

    assign pix_x  = ax_cnt[0];
    assign line_y = ax_cnt[1];
endmodule

// File: tb/sim_rtg_top.sv
module sim_rtg_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        hsync, vsync, blank, disp_en, vevent;
    logic [11:0] pix_x, line_y;

    int n_chk  = 0;
    int n_fail = 0;
    int cycles = 0;
    bit sb_on  = 1'b0;

    // bench reference state: pending / committed register images
    int p [10];
    int c [10];
    int ms, mh, mv;

    always #5 clk = ~clk;

    rtg_top u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .hsync(hsync), .vsync(vsync), .blank(blank), .disp_en(disp_en),
        .pix_x(pix_x), .line_y(line_y), .vevent(vevent)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    function automatic void set_defaults();
        p[0] = 96;  p[1] = 144; p[2] = 784; p[3] = 800;
        p[4] = 2;   p[5] = 35;  p[6] = 515; p[7] = 525;
        p[8] = 515; p[9] = 0;
        c = p;
    endfunction

    function automatic bit bitof(input int v, input int b);
        return bit'((v >> b) & 1);
    endfunction

    function automatic bit e_run();  return ms == 2; endfunction
    function automatic bit e_de();
        return e_run() && mh >= c[1] && mh < c[2] && mv >= c[5] && mv < c[6];
    endfunction
    function automatic bit e_hs();
        return (e_run() && mh < c[0]) ? bitof(c[9], 1) : !bitof(c[9], 1);
    endfunction
    function automatic bit e_vs();
        return (e_run() && mv < c[4]) ? bitof(c[9], 2) : !bitof(c[9], 2);
    endfunction
    function automatic bit e_blank();
        return e_de() ? !bitof(c[9], 3) : bitof(c[9], 3);
    endfunction
    function automatic bit e_vev();
        int evl;
        evl = bitof(c[9], 4) ? c[8] : c[6];
        return e_run() && mh == 0 && mv == evl;
    endfunction

    // reference advance per clock edge; pending image updated after use
    always @(posedge clk) begin
        cycles++;
        if (!rst_n) begin
            set_defaults();
            ms = 0; mh = 0; mv = 0;
        end else begin
            case (ms)
                0: if (bitof(p[9], 0)) ms = 1;
                1: begin c = p; mh = 0; mv = 0; ms = 2; end
                default: begin
                    if (!bitof(p[9], 0)) begin
                        ms = 0; mh = 0; mv = 0;
                    end else if (mh == c[3] - 1) begin
                        mh = 0;
                        if (mv == c[7] - 1) begin mv = 0; c = p; end
                        else mv++;
                    end else mh++;
                end
            endcase
            if (wr_en && int'(wr_addr) < 10)
                p[wr_addr] = (wr_addr == 4'd9) ? int'(wr_data & 16'h1f) : int'(wr_data & 16'hfff);
        end
    end

    // per-cycle scoreboard, away from the active edge
    always @(negedge clk) begin
        if (sb_on) begin
            chk(int'(pix_x) == mh, "R2 R8 pix_x", int'(pix_x), mh);
            chk(int'(line_y) == mv, "R2 line_y", int'(line_y), mv);
            chk(hsync == e_hs(), "R3 R5 hsync", int'(hsync), int'(e_hs()));
            chk(vsync == e_vs(), "R3 R5 vsync", int'(vsync), int'(e_vs()));
            chk(disp_en == e_de(), "R4 R7 disp_en", int'(disp_en), int'(e_de()));
            chk(blank == e_blank(), "R5 blank", int'(blank), int'(e_blank()));
            chk(vevent == e_vev(), "R6 vevent", int'(vevent), int'(e_vev()));
        end
    end

    always @(posedge clk) begin
        if (cycles > 190000) begin
            n_fail++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 190000);
            finish_run();
        end
    end

    task automatic wr(input int a, input int d);
        wr_en = 1'b1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_xy(input int x, input int y);
        while (!(int'(pix_x) == x && (y < 0 || int'(line_y) == y))) @(negedge clk);
    endtask

    initial begin
        int cfg [10];
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(pix_x == 0 && line_y == 0, "R1 counters", int'(pix_x), 0);
        chk(hsync == 1 && vsync == 1, "R1 syncs idle", int'({hsync, vsync}), 3);
        chk(disp_en == 0 && blank == 0 && vevent == 0, "R1 de/blank/vevent",
            int'({disp_en, blank, vevent}), 0);
        sb_on = 1'b1;

        // R10 default timing, R7 start latency
        wr(9, 1);
        @(negedge clk);
        chk(pix_x == 0 && disp_en == 0, "R7 load cycle", int'(pix_x), 0);
        @(negedge clk);
        chk(pix_x == 0 && hsync == 0, "R7 first run cycle hsync", int'(hsync), 0);
        @(negedge clk);
        chk(pix_x == 1, "R7 counting", int'(pix_x), 1);
        wait_xy(95, 0);
        chk(hsync == 0, "R10 hsync last", int'(hsync), 0);
        @(negedge clk);
        chk(hsync == 1, "R10 hsync end at 96", int'(hsync), 1);
        wait_xy(799, 0);
        @(negedge clk);
        chk(pix_x == 0 && line_y == 1, "R10 R2 line wrap at 800", int'(line_y), 1);
        wait_xy(144, 35);
        chk(disp_en == 1, "R10 R4 first active pixel", int'(disp_en), 1);
        wr(9, 0);
        @(negedge clk);
        chk(disp_en == 0 && pix_x == 0 && line_y == 0, "R7 stop", int'(pix_x), 0);

        // R8 shadowing: shrink the line mid-frame
        cfg = '{2, 4, 16, 20, 1, 2, 5, 6, 3, 1};
        for (int a = 0; a < 10; a++) wr(a, cfg[a]);
        wait_xy(0, 2);
        wr(3, 10);
        wait_xy(19, 3);
        @(negedge clk);
        chk(pix_x == 0 && line_y == 4, "R8 old total kept", int'(line_y), 4);
        wait_xy(0, 0);
        wait_xy(9, 0);
        @(negedge clk);
        chk(pix_x == 0 && line_y == 1, "R8 new total applied", int'(pix_x), 0);

        // random timing sets, mid-frame rewrites, unmapped writes
        for (int it = 0; it < 40; it++) begin
            int frame;
            cfg[0] = 1 + int'($urandom % 4);
            cfg[1] = cfg[0] + 1 + int'($urandom % 4);
            cfg[2] = cfg[1] + 1 + int'($urandom % 12);
            cfg[3] = cfg[2] + 1 + int'($urandom % 5);
            cfg[4] = 1 + int'($urandom % 2);
            cfg[5] = cfg[4] + 1 + int'($urandom % 3);
            cfg[6] = cfg[5] + 1 + int'($urandom % 6);
            cfg[7] = cfg[6] + 1 + int'($urandom % 3);
            cfg[8] = int'($urandom % cfg[7]);
            cfg[9] = 1 | int'(($urandom % 16) << 1);
            if (it % 4 == 0) begin
                wr(9, 0);
                @(negedge clk);
            end
            for (int a = 0; a < 10; a++) wr(a, cfg[a]);
            // R9 writes outside the map
            wr(10 + int'($urandom % 6), int'($urandom & 16'hffff));
            frame = cfg[3] * cfg[7];
            repeat (3 * frame) @(negedge clk);
        end

        sb_on = 1'b0;
        finish_run();
    end
endmodule